// File: doc/BRIEF.md
# GPIO Pin Block with Per-Pin Trigger Detection

A sixteen-pin general purpose I/O block behind a small word-addressed register port. Each pin carries an output value, a direction bit and a synchronized input reading. Each pin also has a three-bit trigger code that picks the condition that raises its interrupt.

Detected conditions latch into a sticky status register. Software clears a status bit by writing a 1 to it. Each status bit drives its own interrupt line. The pads are modelled as plain signals: a value, a drive enable and an input.

Register writes take effect on the clock edge where `wr_en` is high. Read data is registered, so `rdata` shows the register selected by `addr` one clock after `addr` is applied.

Top module: `gpio_irq_unit`

## Requirements
- R1: After reset the following hold. `pad_out` is 0. The direction register reads 0xFFFF, so every pin is an input and `pad_oe` is 0. Both trigger registers read 0xFFFFFF, which gives every pin code 7. Status and `irq` are 0.
- R2: The output register at offset 0x00 drives `pad_out` one clock after the write, and it reads back at 0x00.
- R3: The direction register is at offset 0x04. A bit of 1 makes that pin an input (`pad_oe` bit 0). A bit of 0 makes it a driven output (`pad_oe` bit 1).
- R4: Offset 0x08 returns `pad_in` after a two-flop synchronizer. A read issued in the same cycle as a pad change still returns the old value. Writes to 0x08 have no effect.
- R5: Pin p has a 3-bit trigger field at bit position (p mod 8)*3. Pins 0..7 use the register at offset 0x10, and pins 8..15 use the register at offset 0x14.
- R6: Code 0 (level high) sets the status bit on every clock while the synchronized input is 1.
- R7: Code 1 (level low) sets the status bit on every clock while the synchronized input is 0.
- R8: Code 2 (rising edge) sets the status bit once per 0-to-1 transition. A bit cleared while the input stays high remains clear.
- R9: Code 3 (falling edge) sets the status bit once per 1-to-0 transition.
- R10: Code 4 (any transition) sets the status bit on either edge.
- R11: Codes 5, 6 and 7 never set the status bit.
- R12: Status reads at offset 0x0C, and `irq[p]` equals status bit p. Writing 1 to a bit clears it. Writing 0 has no effect. When a trigger is detected in the same clock as the clear, the bit stays set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | 8 | Byte offset of the register |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Registered read data for `addr` |
| pad_in | input | 16 | Pin input levels (asynchronous) |
| pad_out | output | 16 | Pin output values |
| pad_oe | output | 16 | Pin drive enables, 1 = driven |
| irq | output | 16 | Per-pin interrupt, mirrors status |

## Verification
All eight trigger codes are tried, each on its own pin. The pins are spread across both trigger registers so that the field placement is tested as well as the behaviour.

Each pin is run through the same three phases:
- Held low, then cleared. This separates level-low from every other code.
- Raised, checked, then cleared while still held high. This separates level-high, which refuses to clear, from rising and any-edge, which fire only once. It also shows that a stale sticky bit from the earlier phase clears.
- Lowered, checked, then cleared again. This separates falling and any-edge from the rest.

Every check looks at the whole `irq` vector, so a wrong field position shows up as a bit on the wrong pin. Separate checks cover a clear attempted with a zero mask, the input read latency and a write to the read-only input register.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;
  localparam int TRIG_W = 3;
  localparam int PINS_PER_TREG = 8;

  localparam logic [2:0] TRIG_HIGH = 3'd0;
  localparam logic [2:0] TRIG_LOW  = 3'd1;
  localparam logic [2:0] TRIG_RISE = 3'd2;
  localparam logic [2:0] TRIG_FALL = 3'd3;
  localparam logic [2:0] TRIG_ANY  = 3'd4;

  localparam logic [7:0] OFS_OUT  = 8'h00;
  localparam logic [7:0] OFS_DIR  = 8'h04;
  localparam logic [7:0] OFS_IN   = 8'h08;
  localparam logic [7:0] OFS_STAT = 8'h0C;
  localparam logic [7:0] OFS_TLO  = 8'h10;
  localparam logic [7:0] OFS_THI  = 8'h14;
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] meta_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      meta_q <= '0;
      q      <= '0;
    end else begin
      meta_q <= d;
      q      <= meta_q;
    end
  end
endmodule

// File: rtl/gpio_trig.sv
module gpio_trig
  import gpio_irq_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       cur,
  input  logic [2:0] code,
  output logic       hit
);
  logic prev_q;

  always_ff @(posedge clk) begin
    if (rst) prev_q <= 1'b0;
    else     prev_q <= cur;
  end

  always_comb begin
    case (code)
      TRIG_HIGH: hit = cur;
      TRIG_LOW:  hit = ~cur;
      TRIG_RISE: hit = cur & ~prev_q;
      TRIG_FALL: hit = ~cur & prev_q;
      TRIG_ANY:  hit = cur ^ prev_q;
      default:   hit = 1'b0;
    endcase
  end
endmodule

// File: rtl/gpio_status.sv
module gpio_status #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] set,
  input  logic [W-1:0] clr,
  output logic [W-1:0] q
);
  // a detection in the clearing cycle wins so no event is lost
  always_ff @(posedge clk) begin
    if (rst) q <= '0;
    else     q <= (q & ~clr) | set;
  end
endmodule

// File: rtl/gpio_irq_unit.sv
module gpio_irq_unit
  import gpio_irq_pkg::*;
#(
  parameter int NPIN = 16,
  parameter int AW   = 8,
  parameter int DW   = 32
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            wr_en,
  input  logic [AW-1:0]   addr,
  input  logic [DW-1:0]   wdata,
  output logic [DW-1:0]   rdata,
  input  logic [NPIN-1:0] pad_in,
  output logic [NPIN-1:0] pad_out,
  output logic [NPIN-1:0] pad_oe,
  output logic [NPIN-1:0] irq
);
  localparam int FW   = TRIG_W * PINS_PER_TREG;
  localparam int NTRG = (NPIN + PINS_PER_TREG - 1) / PINS_PER_TREG;

  logic [NPIN-1:0] out_q;
  logic [NPIN-1:0] dir_q;
  logic [FW-1:0]   typ_q [2];
  logic [NPIN-1:0] in_sync;
  logic [NPIN-1:0] hit;
  logic [NPIN-1:0] clr;
  logic [NPIN-1:0] stat_q;
  logic [DW-1:0]   rd_mux;
  logic            unused_wbits;

  assign unused_wbits = ^wdata[DW-1:FW];

  always_ff @(posedge clk) begin
    if (rst) begin
      out_q    <= '0;
      dir_q    <= '1;
      typ_q[0] <= '1;
      typ_q[1] <= '1;
    end else if (wr_en) begin
      case (addr)
        AW'(OFS_OUT): out_q    <= wdata[NPIN-1:0];
        AW'(OFS_DIR): dir_q    <= wdata[NPIN-1:0];
        AW'(OFS_TLO): typ_q[0] <= wdata[FW-1:0];
        AW'(OFS_THI): typ_q[1] <= wdata[FW-1:0];
        default: ;
      endcase
    end
  end

  gpio_sync #(.W(NPIN)) u_sync (
    .clk(clk), .rst(rst), .d(pad_in), .q(in_sync)
  );

  for (genvar p = 0; p < NPIN; p++) begin : g_pin
    logic [2:0] code;
    assign code = typ_q[p / PINS_PER_TREG][(p % PINS_PER_TREG) * TRIG_W +: TRIG_W];
    gpio_trig u_trig (
      .clk(clk), .rst(rst), .cur(in_sync[p]), .code(code), .hit(hit[p])
    );
  end

  assign clr = (wr_en && addr == AW'(OFS_STAT)) ? wdata[NPIN-1:0] : '0;

  gpio_status #(.W(NPIN)) u_stat (
    .clk(clk), .rst(rst), .set(hit), .clr(clr), .q(stat_q)
  );

  always_comb begin
    case (addr)
      AW'(OFS_OUT):  rd_mux = {{(DW-NPIN){1'b0}}, out_q};
      AW'(OFS_DIR):  rd_mux = {{(DW-NPIN){1'b0}}, dir_q};
      AW'(OFS_IN):   rd_mux = {{(DW-NPIN){1'b0}}, in_sync};
      AW'(OFS_STAT): rd_mux = {{(DW-NPIN){1'b0}}, stat_q};
      AW'(OFS_TLO):  rd_mux = {{(DW-FW){1'b0}}, typ_q[0]};
      AW'(OFS_THI):  rd_mux = {{(DW-FW){1'b0}}, typ_q[NTRG-1]};
      default:       rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) rdata <= '0;
    else     rdata <= rd_mux;
  end

  assign pad_out = out_q;
  assign pad_oe  = ~dir_q;
  assign irq     = stat_q;
endmodule

// File: rtl/gpio_irq_chk.sv
module gpio_irq_chk
  import gpio_irq_pkg::*;
#(
  parameter int NPIN = 16,
  parameter int AW   = 8,
  parameter int DW   = 32
) (
  input logic            clk,
  input logic            rst,
  input logic            wr_en,
  input logic [AW-1:0]   addr,
  input logic [DW-1:0]   wdata,
  input logic [NPIN-1:0] pad_out,
  input logic [NPIN-1:0] pad_oe,
  input logic [NPIN-1:0] irq,
  input logic [2:0]      pin0_code
);
  a_r1_reset_state: assert property (@(posedge clk)
    rst |=> (irq == '0 && pad_oe == '0 && pad_out == '0));

  a_r2_out_write: assert property (@(posedge clk) disable iff (rst)
    (wr_en && addr == AW'(OFS_OUT)) |=> pad_out == $past(wdata[NPIN-1:0]));

  a_r3_dir_write: assert property (@(posedge clk) disable iff (rst)
    (wr_en && addr == AW'(OFS_DIR)) |=> pad_oe == ~$past(wdata[NPIN-1:0]));

  a_r11_disabled_quiet: assert property (@(posedge clk) disable iff (rst)
    (pin0_code >= 3'd5) |=> !$rose(irq[0]));

  a_r12_sticky: assert property (@(posedge clk) disable iff (rst)
    !(wr_en && addr == AW'(OFS_STAT)) |=> ((irq & $past(irq)) == $past(irq)));

  a_r12_clear_disabled: assert property (@(posedge clk) disable iff (rst)
    (wr_en && addr == AW'(OFS_STAT) && wdata[0] && pin0_code >= 3'd5) |=> !irq[0]);
endmodule

bind gpio_irq_unit gpio_irq_chk #(.NPIN(NPIN), .AW(AW), .DW(DW)) u_chk (
  .clk(clk), .rst(rst), .wr_en(wr_en), .addr(addr), .wdata(wdata),
  .pad_out(pad_out), .pad_oe(pad_oe), .irq(irq), .pin0_code(typ_q[0][2:0])
);

// File: tb/gpio_irq_unit_bench.sv
`timescale 1ns/1ps
module gpio_irq_unit_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic [7:0]  addr = 8'h00;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [15:0] pad_in = '0;
  logic [15:0] pad_out, pad_oe, irq;

  int nchk = 0;
  int nerr = 0;
  logic [23:0] tlo = 24'hFFFFFF;
  logic [23:0] thi = 24'hFFFFFF;

  always #2.5 clk = ~clk;

  gpio_irq_unit u_gpio_irq_unit (
    .clk(clk), .rst(rst), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .rdata(rdata), .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe), .irq(irq)
  );

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(logic [7:0] a, logic [31:0] d);
    @(negedge clk); wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd(logic [7:0] a, output logic [31:0] d);
    @(negedge clk); addr = a;
    @(negedge clk); d = rdata;
  endtask

  task automatic waitn(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic set_code(int p, logic [2:0] c);
    if (p < 8) begin tlo[p*3 +: 3] = c; wr(8'h10, {8'h00, tlo}); end
    else       begin thi[(p-8)*3 +: 3] = c; wr(8'h14, {8'h00, thi}); end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nerr++; nchk++;
    $display("FAIL watchdog: actual=hung expected=finished");
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end

  initial begin
    logic [31:0] r;
    waitn(3);
    rst = 1'b0;
    waitn(1);
    // R1 reset state
    chk("R1 irq", {16'h0, irq}, 32'h0);
    chk("R1 pad_oe", {16'h0, pad_oe}, 32'h0);
    chk("R1 pad_out", {16'h0, pad_out}, 32'h0);
    rd(8'h04, r); chk("R1 dir", r, 32'h0000FFFF);
    rd(8'h10, r); chk("R1 type lo", r, 32'h00FFFFFF);
    rd(8'h14, r); chk("R1 type hi", r, 32'h00FFFFFF);

    // R2 output register
    wr(8'h00, 32'hFFFFA5C3);
    chk("R2 pad_out", {16'h0, pad_out}, 32'h0000A5C3);
    rd(8'h00, r); chk("R2 readback", r, 32'h0000A5C3);

    // R3 direction
    wr(8'h04, 32'h000000FF);
    chk("R3 pad_oe", {16'h0, pad_oe}, 32'h0000FF00);
    rd(8'h04, r); chk("R3 readback", r, 32'h000000FF);

    // R4 input path, all trigger codes disabled
    pad_in = 16'h3C5A; waitn(4);
    rd(8'h08, r); chk("R4 input", r, 32'h00003C5A);
    @(negedge clk); pad_in = 16'h8001; addr = 8'h08;
    @(negedge clk); chk("R4 latency old value", rdata, 32'h00003C5A);
    waitn(3);
    wr(8'h08, 32'h00000000);
    rd(8'h08, r); chk("R4 write ignored", r, 32'h00008001);
    pad_in = 16'h0000; waitn(4);
    chk("R11 disabled no status", {16'h0, irq}, 32'h0);

    // R12 zero write has no effect
    set_code(0, 3'd2);
    pad_in[0] = 1'b1; waitn(4);
    chk("R8 rise pin0", {16'h0, irq}, 32'h1);
    wr(8'h0C, 32'h0);
    chk("R12 zero write keeps", {16'h0, irq}, 32'h1);
    wr(8'h0C, 32'h1);
    chk("R12 one write clears", {16'h0, irq}, 32'h0);
    pad_in[0] = 1'b0; set_code(0, 3'd7); waitn(4);
    wr(8'h0C, 32'hFFFF);

    // R5..R11 each code on its own pin across both registers
    for (int c = 0; c < 8; c++) begin
      int p;
      logic [15:0] m;
      logic ea, eb, ebc, ec, ecc;
      p = c * 2 + 1;
      m = 16'(1) << p;
      ea  = (c == 1);
      eb  = (c == 0) || (c == 1) || (c == 2) || (c == 4);
      ebc = (c == 0);
      ec  = (c == 0) || (c == 1) || (c == 3) || (c == 4);
      ecc = (c == 1);
      set_code(p, 3'(c));
      waitn(4);
      wr(8'h0C, 32'hFFFF); waitn(1);
      chk($sformatf("R5 R7 code%0d low phase", c), {16'h0, irq}, ea ? {16'h0, m} : 32'h0);
      pad_in[p] = 1'b1; waitn(4);
      chk($sformatf("R6 R8 R10 code%0d after rise", c), {16'h0, irq}, eb ? {16'h0, m} : 32'h0);
      rd(8'h0C, r);
      chk($sformatf("R12 status read code%0d", c), r, eb ? {16'h0, m} : 32'h0);
      wr(8'h0C, 32'hFFFF); waitn(1);
      chk($sformatf("R6 R8 code%0d cleared while high", c), {16'h0, irq}, ebc ? {16'h0, m} : 32'h0);
      pad_in[p] = 1'b0; waitn(4);
      chk($sformatf("R9 R10 code%0d after fall", c), {16'h0, irq}, ec ? {16'h0, m} : 32'h0);
      wr(8'h0C, 32'hFFFF); waitn(1);
      chk($sformatf("R7 R11 code%0d cleared while low", c), {16'h0, irq}, ecc ? {16'h0, m} : 32'h0);
      set_code(p, 3'd7);
      wr(8'h0C, 32'hFFFF);
    end

    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end
endmodule